// File: doc/BRIEF.md
# Differential pixel-pair row reader

This block is the digital back end of a photodetector array in which each data bit is carried by two neighbouring pixels, not by one. A read request names one of the array's rows, in any order, and comes with the digitized brightness words of every pixel in that row. Each pixel is called bright or dark against a programmable threshold. Each adjacent pixel pair is then reduced to a single bit. The resulting word is captured in output latches, and a one-cycle valid strobe marks it.

The two legal pair states decode to 1 and 0. The two illegal states behave differently from each other. A pair that is bright in both pixels settles to 0. A pair that is dark in both pixels has no reliable value, so the block supplies a pseudo-random bit from an internal LFSR for it and raises an error flag. A 32-bit mask records every pair in the latched row that was in either illegal state.

Top module: `pair_row_reader`

## Requirements
- R1: Pair i is formed from pixel 2i (first) and pixel 2i+1 (second), and its result lands in bit i of `data_o`. Dark first with bright second gives 1. Bright first with dark second gives 0.
- R2: A pixel is bright when its brightness word, taken from `pix_i[k*PIX_W +: PIX_W]` for pixel k, is greater than or equal to the threshold register. The threshold resets to 128. A cycle with `thr_we_i` high loads `thr_i` into it, and the new value applies to requests sampled on later clock edges.
- R3: A bright-bright pair gives data bit 0 and sets its bit in `err_mask_o`. It does not raise `err_o` by itself.
- R4: A dark-dark pair sets its bit in `err_mask_o` and drives `err_o` high for that row. Its data bit is taken from the internal LFSR.
- R5: `valid_o` is high in the cycle after a clock edge that samples `rd_req_i` high, and low after an edge that samples it low.
- R6: `data_o`, `err_mask_o`, `err_o` and `row_o` keep their latched values until the next request, whatever `pix_i` and `row_addr_i` do in between.
- R7: `row_o` returns the address sampled with the request. Rows may be requested in any order.
- R8: After reset, `valid_o`, `data_o`, `err_mask_o`, `err_o` and `row_o` are all zero.
- R9: The LFSR never reaches the all-zero state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| thr_we_i | input | 1 | Threshold write enable |
| thr_i | input | PIX_W | New threshold value |
| rd_req_i | input | 1 | Row read request |
| row_addr_i | input | ROW_W | Requested row address |
| pix_i | input | NPIX*PIX_W | Brightness words of the selected row, pixel k at bits k*PIX_W and up |
| valid_o | output | 1 | Latched row is fresh (one-cycle strobe) |
| row_o | output | ROW_W | Address of the latched row |
| data_o | output | NPIX/2 | Decoded pair bits |
| err_mask_o | output | NPIX/2 | Illegal pair mask, bit i for pixels 2i and 2i+1 |
| err_o | output | 1 | Latched row contains a dark-dark pair |

## Verification
Several properties are checked on every cycle by the assertions:
- the strobe follows the request by exactly one cycle;
- the latched word, mask and row stay stable while no request is sampled;
- the row echo matches the sampled address;
- a raised error flag always comes with a non-empty mask;
- the LFSR state is never zero.

Other behaviour can only be shown by the bench's scenarios:
- the pair decode itself, with the bit order and both legal polarities;
- the asymmetric treatment of the two illegal states;
- the inclusive threshold boundary;
- the delayed effect of a threshold write.

// File: rtl/pair_row_pkg.sv
package pair_row_pkg;
  typedef enum logic [1:0] {
    PAIR_ZERO = 2'd0,  // bright then dark
    PAIR_ONE  = 2'd1,  // dark then bright
    PAIR_BB   = 2'd2,  // both bright, illegal
    PAIR_DD   = 2'd3   // both dark, illegal
  } pair_state_e;
endpackage

// File: rtl/pix_classify.sv
module pix_classify #(
  parameter int NPIX  = 64,
  parameter int PIX_W = 8
) (
  input  logic [NPIX*PIX_W-1:0] pix_i,
  input  logic [PIX_W-1:0]      thr_i,
  output logic [NPIX-1:0]       bright_o
);
  for (genvar k = 0; k < NPIX; k++) begin : g_pix
    assign bright_o[k] = (pix_i[k*PIX_W +: PIX_W] >= thr_i);
  end
endmodule

// File: rtl/pair_decode.sv
module pair_decode
  import pair_row_pkg::*;
#(
  parameter int NPAIR = 32
) (
  input  logic [2*NPAIR-1:0] bright_i,
  input  logic [NPAIR-1:0]   rnd_i,
  output logic [NPAIR-1:0]   bit_o,
  output logic [NPAIR-1:0]   illegal_o,
  output logic [NPAIR-1:0]   dd_o
);
  for (genvar i = 0; i < NPAIR; i++) begin : g_pair
    pair_state_e st;
    always_comb begin
      unique case ({bright_i[2*i], bright_i[2*i+1]})
        2'b01:   st = PAIR_ONE;
        2'b10:   st = PAIR_ZERO;
        2'b11:   st = PAIR_BB;
        default: st = PAIR_DD;
      endcase
    end
    always_comb begin
      bit_o[i]     = 1'b0;
      illegal_o[i] = 1'b0;
      dd_o[i]      = 1'b0;
      unique case (st)
        PAIR_ONE:  bit_o[i] = 1'b1;
        PAIR_ZERO: bit_o[i] = 1'b0;
        PAIR_BB:   illegal_o[i] = 1'b1;
        PAIR_DD: begin
          bit_o[i]     = rnd_i[i];
          illegal_o[i] = 1'b1;
          dd_o[i]      = 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/flicker_lfsr.sv
module flicker_lfsr #(
  parameter int          W    = 32,
  parameter logic [W-1:0] TAPS = W'(32'h8020_0003),
  parameter logic [W-1:0] SEED = W'(32'hACE1_2468)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] q;

  // Galois right shift; a set MSB in TAPS keeps the state nonzero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= SEED;
    else if (step_i) q <= q[0] ? ((q >> 1) ^ TAPS) : (q >> 1);
  end

  assign state_o = q;

  assert_lfsr_nonzero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q != '0);
endmodule

// File: rtl/pair_row_reader.sv
module pair_row_reader #(
  parameter int          NPIX    = 64,
  parameter int          PIX_W   = 8,
  parameter int          ROWS    = 64,
  parameter logic [PIX_W-1:0] THR_RST = PIX_W'(128),
  localparam int         NPAIR   = NPIX / 2,
  localparam int         ROW_W   = $clog2(ROWS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  thr_we_i,
  input  logic [PIX_W-1:0]      thr_i,
  input  logic                  rd_req_i,
  input  logic [ROW_W-1:0]      row_addr_i,
  input  logic [NPIX*PIX_W-1:0] pix_i,
  output logic                  valid_o,
  output logic [ROW_W-1:0]      row_o,
  output logic [NPAIR-1:0]      data_o,
  output logic [NPAIR-1:0]      err_mask_o,
  output logic                  err_o
);
  logic [PIX_W-1:0] thr_q;
  logic [NPIX-1:0]  bright;
  logic [NPAIR-1:0] rnd, bits, illegal, dd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       thr_q <= THR_RST;
    else if (thr_we_i) thr_q <= thr_i;
  end

  pix_classify #(.NPIX(NPIX), .PIX_W(PIX_W)) u_classify (
    .pix_i    (pix_i),
    .thr_i    (thr_q),
    .bright_o (bright)
  );

  flicker_lfsr #(.W(NPAIR)) u_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (rd_req_i),
    .state_o (rnd)
  );

  pair_decode #(.NPAIR(NPAIR)) u_decode (
    .bright_i  (bright),
    .rnd_i     (rnd),
    .bit_o     (bits),
    .illegal_o (illegal),
    .dd_o      (dd)
  );

  // output latches: read from here, never from the live decode
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      row_o      <= '0;
      data_o     <= '0;
      err_mask_o <= '0;
      err_o      <= 1'b0;
    end else begin
      valid_o <= rd_req_i;
      if (rd_req_i) begin
        row_o      <= row_addr_i;
        data_o     <= bits;
        err_mask_o <= illegal;
        err_o      <= |dd;
      end
    end
  end

  assert_valid_follows_req_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_i |=> valid_o);
  assert_valid_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req_i |=> !valid_o);
  assert_latch_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req_i |=> ($stable(data_o) && $stable(err_mask_o) && $stable(row_o) && $stable(err_o)));
  assert_row_echo_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_i |=> (row_o == $past(row_addr_i)));
  assert_err_in_mask_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (err_mask_o != '0));
endmodule

// File: tb/pair_row_reader_tb_top.sv
module pair_row_reader_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NPIX  = 64;
  localparam int PIX_W = 8;
  localparam int NPAIR = 32;
  localparam int ROW_W = 6;
  localparam logic [7:0] DK = 8'h10;
  localparam logic [7:0] BR = 8'hF0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic thr_we = 1'b0;
  logic [PIX_W-1:0] thr = '0;
  logic rd_req = 1'b0;
  logic [ROW_W-1:0] row_addr = '0;
  logic [NPIX*PIX_W-1:0] pix_flat;
  logic [PIX_W-1:0] pix_w [NPIX];
  logic valid;
  logic [ROW_W-1:0] row;
  logic [NPAIR-1:0] data, mask;
  logic err;

  int vectors = 0;
  int fails = 0;

  // expected state, computed from the requirements
  logic [NPAIR-1:0] exp_data, exp_mask, dd_mask;
  logic exp_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb
    for (int k = 0; k < NPIX; k++) pix_flat[k*PIX_W +: PIX_W] = pix_w[k];

  pair_row_reader dut_i (
    .clk_i(clk), .rst_ni(rst_n), .thr_we_i(thr_we), .thr_i(thr),
    .rd_req_i(rd_req), .row_addr_i(row_addr), .pix_i(pix_flat),
    .valid_o(valid), .row_o(row), .data_o(data), .err_mask_o(mask), .err_o(err)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // code: 0 bright-dark, 1 dark-bright, 2 bright-bright, 3 dark-dark
  task automatic set_pair(input int i, input int code);
    case (code)
      0: begin pix_w[2*i] = BR; pix_w[2*i+1] = DK; end
      1: begin pix_w[2*i] = DK; pix_w[2*i+1] = BR; end
      2: begin pix_w[2*i] = BR; pix_w[2*i+1] = BR; end
      default: begin pix_w[2*i] = DK; pix_w[2*i+1] = DK; end
    endcase
    exp_data[i] = (code == 1);
    exp_mask[i] = (code >= 2);
    dd_mask[i]  = (code == 3);
    exp_err     = |dd_mask;
  endtask

  task automatic load_word(input logic [NPAIR-1:0] w);
    for (int i = 0; i < NPAIR; i++) set_pair(i, w[i] ? 1 : 0);
  endtask

  task automatic write_thr(input logic [PIX_W-1:0] v);
    @(negedge clk); thr = v; thr_we = 1'b1;
    @(negedge clk); thr_we = 1'b0;
  endtask

  task automatic read_row(input logic [ROW_W-1:0] r, input string tag);
    @(negedge clk); row_addr = r; rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
    check(valid === 1'b1, {tag, " R5 valid"}, 64'(valid), 64'd1);
    check((data & ~dd_mask) === exp_data, {tag, " R1 data"}, 64'(data), 64'(exp_data));
    check(mask === exp_mask, {tag, " mask"}, 64'(mask), 64'(exp_mask));
    check(err === exp_err, {tag, " err"}, 64'(err), 64'(exp_err));
    check(row === r, {tag, " R7 row"}, 64'(row), 64'(r));
    @(negedge clk);
    check(valid === 1'b0, {tag, " R5 pulse"}, 64'(valid), 64'd0);
  endtask

  task automatic t_reset;
    check(valid === 1'b0 && data === '0 && mask === '0 && err === 1'b0 && row === '0,
          "R8 reset", {valid, err, row, data[23:0]}, 64'd0);
  endtask

  task automatic t_alternating;
    for (int i = 0; i < NPAIR; i++) set_pair(i, i % 2);
    read_row(6'd5, "R1 alternating");
  endtask

  task automatic t_any_order;
    load_word(32'hA5C3_0F96); read_row(6'd63, "R7 row63");
    load_word(32'h0000_0001); read_row(6'd0,  "R7 row0");
    load_word(32'h8000_0000); read_row(6'd42, "R1 msb");
    load_word(32'hFFFF_FFFF); read_row(6'd17, "R1 ones");
  endtask

  task automatic t_bright_bright;
    load_word(32'hFFFF_FFFF);
    set_pair(3, 2); set_pair(17, 2);
    read_row(6'd9, "R3 bright-bright");
    check(data[3] === 1'b0 && data[17] === 1'b0, "R3 bb zero", 64'(data), 64'(exp_data));
  endtask

  task automatic t_dark_dark;
    load_word(32'h1234_5678);
    set_pair(0, 3); set_pair(31, 3); set_pair(12, 2);
    read_row(6'd33, "R4 dark-dark");
    check(err === 1'b1, "R4 err flag", 64'(err), 64'd1);
    for (int i = 0; i < NPAIR; i++) dd_mask[i] = 1'b0;
  endtask

  task automatic t_hold;
    logic [NPAIR-1:0] held;
    load_word(32'h0F0F_F0F0); read_row(6'd21, "R6 base");
    held = data;
    for (int k = 0; k < NPIX; k++) pix_w[k] = DK;
    row_addr = 6'd2;
    repeat (4) @(negedge clk);
    check(data === held && valid === 1'b0, "R6 hold data", 64'(data), 64'(held));
    check(row === 6'd21 && mask === '0 && err === 1'b0, "R6 hold row", 64'(row), 64'd21);
  endtask

  task automatic t_threshold;
    for (int i = 0; i < NPAIR; i++) set_pair(i, 0);
    pix_w[0] = 8'h7F; pix_w[1] = 8'h80;   // pair 0: dark/bright at 128
    exp_data[0] = 1'b1; exp_mask[0] = 1'b0; dd_mask[0] = 1'b0; exp_err = 1'b0;
    read_row(6'd1, "R2 boundary at reset thr");
    write_thr(8'h81);                     // 0x80 is now dark too
    exp_data[0] = 1'b0; exp_mask[0] = 1'b1; dd_mask[0] = 1'b1; exp_err = 1'b1;
    read_row(6'd1, "R2 after thr write");
    write_thr(8'h7F);                     // both bright now
    exp_mask[0] = 1'b1; dd_mask[0] = 1'b0; exp_err = 1'b0;
    read_row(6'd1, "R2 low thr");
    check(data[0] === 1'b0, "R2 R3 bb at low thr", 64'(data), 64'd0);
    write_thr(8'h80);
  endtask

  initial begin
    exp_data = '0; exp_mask = '0; dd_mask = '0; exp_err = 1'b0;
    for (int k = 0; k < NPIX; k++) pix_w[k] = DK;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_alternating();
    t_any_order();
    t_bright_bright();
    t_dark_dark();
    t_hold();
    t_threshold();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    vectors++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule